// File: doc/BRIEF.md
# Shared Configuration Word Router

This block sits behind a single host-to-device FIFO that carries settings for several on-chip subsystems. Each 64-bit word carries an opcode and a subsystem identifier. The block forwards writes and reads to the identified subsystem only, using one-cycle strobes on a shared address and data bus. It pops the FIFO only when the target can take the command. The host polls a small set of status outputs: a readback register with a valid flag, a batch-done flag with a batch sequence number, and a sticky error flag. Each flag has its own host acknowledge or clear input.

A batch of settings ends with an end-of-batch word. The done flag rises only once every earlier write has been handed to its subsystem, so the host gets one confirmation for the whole download. Two copies of the block can serve separate acquisition and generation streams. A resource both must reach, such as clocking, is attached to the same identifier in both copies, and arbitration between the two copies is handled outside this block.

Top module: `cfg_word_router`

## Requirements
- R1: While `rst` is high, `fifo_ready`, `sub_wr_en`, `sub_rd_en`, `rb_valid`, `batch_done` and `err_flag` are 0 and `batch_seq` is 0, even when a word is waiting in the FIFO.
- R2: A word with bits [63:60] = 1 (write) and bits [59:56] = s < NUM_SUB is popped. In the next cycle, `sub_wr_en` is one-hot on bit s for exactly one cycle, with `sub_addr` = bits [55:40] and `sub_wdata` = bits [31:0]. No other subsystem sees a strobe.
- R3: A write or read word whose target has `sub_ready` low is not popped and raises no strobe. It proceeds as soon as that ready bit rises.
- R4: A word with opcode 2 (read) raises `sub_rd_en[s]` one cycle after its pop. The subsystem's `sub_rdata` slice is captured two cycles after the pop, and `rb_data`/`rb_valid` show it one cycle later. `rb_valid` stays high until `host_ack_rb`. The FIFO is not popped while a read is in flight.
- R5: If a read capture and `host_ack_rb` fall in the same cycle, the capture wins: `rb_valid` stays 1 with the new data.
- R6: A word with opcode 3 (end-of-batch, identifier ignored) is not popped while any write strobe is pending. When it is popped, `batch_done` rises and `batch_seq` increments by one (modulo 2^SEQ_W) in the next cycle. `batch_done` clears on `host_ack_done`, and a new done wins over a same-cycle acknowledge.
- R7: A word with opcode other than 1, 2 or 3, or with a write or read identifier at or above NUM_SUB, is popped without any strobe. It sets `err_flag`, which stays set until `host_clr_err`; a new error wins over a same-cycle clear.
- R8: `fifo_ready` is never high while `fifo_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_valid | input | 1 | FIFO head word is present |
| fifo_data | input | 64 | FIFO head word |
| fifo_ready | output | 1 | Pop the head word this cycle |
| sub_ready | input | NUM_SUB | Per-subsystem ability to take a strobe next cycle |
| sub_wr_en | output | NUM_SUB | One-cycle write strobes |
| sub_rd_en | output | NUM_SUB | One-cycle read strobes |
| sub_addr | output | 16 | Shared register address |
| sub_wdata | output | 32 | Shared write data |
| sub_rdata | input | NUM_SUB*32 | Per-subsystem read data, slice s for subsystem s, valid the cycle after its read strobe |
| host_ack_rb | input | 1 | Clears the readback-valid flag |
| host_ack_done | input | 1 | Clears the batch-done flag |
| host_clr_err | input | 1 | Clears the error flag |
| rb_data | output | 32 | Last captured readback value |
| rb_valid | output | 1 | Readback value is fresh |
| batch_done | output | 1 | Last batch fully applied |
| batch_seq | output | SEQ_W | Count of completed batches |
| err_flag | output | 1 | Sticky malformed-command flag |

## Verification
Two pairs of events can fall in the same cycle. A readback capture can coincide with the host's acknowledge of an earlier readback. A dropped malformed word can coincide with the host's error clear. The bench leaves one readback unacknowledged, queues a second read, and holds `host_ack_rb` high exactly in the capture cycle; it then expects `rb_valid` still set with the second value. It also pushes a word with a bad identifier while pulsing `host_clr_err` on the edge that pops it, and expects `err_flag` to end up set.

// File: rtl/crd_pkg.sv
`timescale 1ns/1ps
package crd_pkg;
  localparam int WORD_W = 64;
  localparam int OP_W   = 4;
  localparam int ID_W   = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int PAD_W  = WORD_W - OP_W - ID_W - ADDR_W - DATA_W;

  localparam logic [OP_W-1:0] OPC_WRITE = 4'd1;
  localparam logic [OP_W-1:0] OPC_READ  = 4'd2;
  localparam logic [OP_W-1:0] OPC_EOB   = 4'd3;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ID_W-1:0]   sid;
    logic [ADDR_W-1:0] addr;
    logic [PAD_W-1:0]  pad;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef enum logic [2:0] {K_NONE, K_WR, K_RD, K_EOB, K_BAD} kind_e;
endpackage

// File: rtl/crd_decode.sv
`timescale 1ns/1ps
module crd_decode
  import crd_pkg::*;
#(
  parameter int NUM_SUB = 4,
  localparam int IDX_W = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
  input  cmd_t              cmd,
  input  logic              valid,
  output kind_e             kind,
  output logic [IDX_W-1:0]  idx
);
  logic sid_ok;

  always_comb begin
    sid_ok = (int'(cmd.sid) < NUM_SUB);
    idx    = cmd.sid[IDX_W-1:0];
    if (!valid) begin
      kind = K_NONE;
    end else begin
      unique case (cmd.op)
        OPC_WRITE: kind = sid_ok ? K_WR : K_BAD;
        OPC_READ:  kind = sid_ok ? K_RD : K_BAD;
        OPC_EOB:   kind = K_EOB;
        default:   kind = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/crd_fanout.sv
`timescale 1ns/1ps
module crd_fanout
  import crd_pkg::*;
#(
  parameter int NUM_SUB = 4,
  localparam int IDX_W = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issue_wr,
  input  logic                issue_rd,
  input  logic [IDX_W-1:0]    idx,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic [DATA_W-1:0]   data_in,
  output logic [NUM_SUB-1:0]  wr_en,
  output logic [NUM_SUB-1:0]  rd_en,
  output logic [ADDR_W-1:0]   addr,
  output logic [DATA_W-1:0]   wdata,
  output logic                cap_now,
  output logic [IDX_W-1:0]    cap_idx,
  output logic                busy_wr,
  output logic                busy_rd
);
  for (genvar s = 0; s < NUM_SUB; s++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        wr_en[s] <= 1'b0;
        rd_en[s] <= 1'b0;
      end else begin
        wr_en[s] <= issue_wr && (idx == IDX_W'(s));
        rd_en[s] <= issue_rd && (idx == IDX_W'(s));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      wdata   <= '0;
      cap_now <= 1'b0;
      cap_idx <= '0;
    end else begin
      if (issue_wr || issue_rd) begin
        addr  <= addr_in;
        wdata <= data_in;
      end
      if (issue_rd) cap_idx <= idx;
      cap_now <= |rd_en;
    end
  end

  assign busy_wr = |wr_en;
  assign busy_rd = (|rd_en) || cap_now;

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en)); // R2
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (|wr_en) && !issue_wr |=> !(|wr_en)); // R2
  AST_RD_THEN_CAP: assert property (@(posedge clk) disable iff (rst)
    (|rd_en) |=> cap_now); // R4
endmodule

// File: rtl/crd_status.sv
`timescale 1ns/1ps
module crd_status
  import crd_pkg::*;
#(
  parameter int NUM_SUB = 4,
  parameter int SEQ_W   = 8,
  localparam int IDX_W = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cap_now,
  input  logic [IDX_W-1:0]           cap_idx,
  input  logic [NUM_SUB*DATA_W-1:0]  sub_rdata,
  input  logic                       ack_rb,
  input  logic                       eob_pop,
  input  logic                       ack_done,
  input  logic                       bad_pop,
  input  logic                       clr_err,
  output logic [DATA_W-1:0]          rb_data,
  output logic                       rb_valid,
  output logic                       done,
  output logic [SEQ_W-1:0]           seq,
  output logic                       err
);
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      rb_data  <= '0;
      rb_valid <= 1'b0;
      done     <= 1'b0;
      seq      <= '0;
      err      <= 1'b0;
    end else begin
      if (cap_now) begin
        rb_data  <= sub_rdata[cap_idx*DATA_W +: DATA_W];
        rb_valid <= 1'b1;
      end else if (ack_rb) begin
        rb_valid <= 1'b0;
      end
      if (eob_pop) begin
        done <= 1'b1;
        seq  <= seq + 1'b1;
      end else if (ack_done) begin
        done <= 1'b0;
      end
      if (bad_pop)      err <= 1'b1;
      else if (clr_err) err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RST_CLEAR: assert (!rb_valid && !done && !err && seq == '0); // R1
    end
  end

  AST_RB_HOLD: assert property (@(posedge clk) disable iff (rst)
    rb_valid && !ack_rb |=> rb_valid); // R4
  AST_CAP_WINS: assert property (@(posedge clk) disable iff (rst)
    cap_now && ack_rb |=> rb_valid); // R5
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    eob_pop |=> done && (seq == $past(seq) + 1'b1)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err && !clr_err |=> err); // R7
endmodule

// File: rtl/cfg_word_router.sv
`timescale 1ns/1ps
module cfg_word_router
  import crd_pkg::*;
#(
  parameter int NUM_SUB = 4,
  parameter int SEQ_W   = 8,
  localparam int IDX_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
  localparam int RD_W   = NUM_SUB * 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fifo_valid,
  input  logic [63:0]         fifo_data,
  output logic                fifo_ready,
  input  logic [NUM_SUB-1:0]  sub_ready,
  output logic [NUM_SUB-1:0]  sub_wr_en,
  output logic [NUM_SUB-1:0]  sub_rd_en,
  output logic [15:0]         sub_addr,
  output logic [31:0]         sub_wdata,
  input  logic [RD_W-1:0]     sub_rdata,
  input  logic                host_ack_rb,
  input  logic                host_ack_done,
  input  logic                host_clr_err,
  output logic [31:0]         rb_data,
  output logic                rb_valid,
  output logic                batch_done,
  output logic [SEQ_W-1:0]    batch_seq,
  output logic                err_flag
);
  cmd_t             head;
  kind_e            kind;
  logic [IDX_W-1:0] idx;
  logic             busy_wr, busy_rd, cap_now, pop;
  logic [IDX_W-1:0] cap_idx;

  assign head = cmd_t'(fifo_data);

  crd_decode #(.NUM_SUB(NUM_SUB)) u_dec (
    .cmd(head), .valid(fifo_valid), .kind(kind), .idx(idx)
  );

  // Strict in-order issue: nothing leaves the FIFO while a read is in flight.
  always_comb begin
    pop = 1'b0;
    if (!rst && !busy_rd) begin
      unique case (kind)
        K_WR, K_RD: pop = sub_ready[idx];
        K_EOB:      pop = !busy_wr;
        K_BAD:      pop = 1'b1;
        default:    pop = 1'b0;
      endcase
    end
  end
  assign fifo_ready = pop;

  crd_fanout #(.NUM_SUB(NUM_SUB)) u_fan (
    .clk(clk), .rst(rst),
    .issue_wr(pop && kind == K_WR), .issue_rd(pop && kind == K_RD),
    .idx(idx), .addr_in(head.addr), .data_in(head.data),
    .wr_en(sub_wr_en), .rd_en(sub_rd_en), .addr(sub_addr), .wdata(sub_wdata),
    .cap_now(cap_now), .cap_idx(cap_idx), .busy_wr(busy_wr), .busy_rd(busy_rd)
  );

  crd_status #(.NUM_SUB(NUM_SUB), .SEQ_W(SEQ_W)) u_stat (
    .clk(clk), .rst(rst), .cap_now(cap_now), .cap_idx(cap_idx),
    .sub_rdata(sub_rdata), .ack_rb(host_ack_rb),
    .eob_pop(pop && kind == K_EOB), .ack_done(host_ack_done),
    .bad_pop(pop && kind == K_BAD), .clr_err(host_clr_err),
    .rb_data(rb_data), .rb_valid(rb_valid), .done(batch_done),
    .seq(batch_seq), .err(err_flag)
  );

  AST_POP_VALID: assert property (@(posedge clk) disable iff (rst)
    fifo_ready |-> fifo_valid); // R8
  AST_EOB_QUIET: assert property (@(posedge clk) disable iff (rst)
    fifo_ready && kind == K_EOB |-> !(|sub_wr_en)); // R6
  AST_BAD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    fifo_ready && kind == K_BAD |=> !(|sub_wr_en) && !(|sub_rd_en)); // R7

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_chk
    AST_STROBE_READY: assert property (@(posedge clk) disable iff (rst)
      (sub_wr_en[s] || sub_rd_en[s]) |-> $past(sub_ready[s])); // R3
  end
endmodule

// File: tb/cfg_word_router_tb.sv
`timescale 1ns/1ps
module cfg_word_router_tb;
  localparam int NS = 4;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [63:0] q [0:63];
  int head = 0, tail = 0;
  logic fifo_valid, fifo_ready;
  logic [63:0] fifo_data;
  logic [NS-1:0] sub_ready = '1;
  logic [NS-1:0] sub_wr_en, sub_rd_en;
  logic [15:0] sub_addr;
  logic [31:0] sub_wdata, rb_data;
  logic [NS*32-1:0] sub_rdata;
  logic host_ack_rb = 0, host_ack_done = 0, host_clr_err = 0;
  logic rb_valid, batch_done, err_flag;
  logic [SW-1:0] batch_seq;

  assign fifo_valid = (head != tail);
  assign fifo_data  = q[head[5:0]];

  cfg_word_router #(.NUM_SUB(NS), .SEQ_W(SW)) u_dut (
    .clk(clk), .rst(rst), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_ready(fifo_ready), .sub_ready(sub_ready), .sub_wr_en(sub_wr_en),
    .sub_rd_en(sub_rd_en), .sub_addr(sub_addr), .sub_wdata(sub_wdata),
    .sub_rdata(sub_rdata), .host_ack_rb(host_ack_rb),
    .host_ack_done(host_ack_done), .host_clr_err(host_clr_err),
    .rb_data(rb_data), .rb_valid(rb_valid), .batch_done(batch_done),
    .batch_seq(batch_seq), .err_flag(err_flag)
  );

  // Subsystem models: 16-entry register files, registered read data.
  logic [31:0] mem [NS][16];
  logic [31:0] rdq [NS];
  int wr_cnt [NS] = '{0, 0, 0, 0};
  assign sub_rdata = {rdq[3], rdq[2], rdq[1], rdq[0]};

  always @(posedge clk) begin
    if (fifo_ready) head <= head + 1;
    for (int s = 0; s < NS; s++) begin
      if (sub_wr_en[s]) begin
        mem[s][sub_addr[3:0]] <= sub_wdata;
        wr_cnt[s] <= wr_cnt[s] + 1;
      end
      if (sub_rd_en[s]) rdq[s] <= mem[s][sub_addr[3:0]];
    end
  end

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [3:0] op, input logic [3:0] sid,
                                     input logic [15:0] a, input logic [31:0] d);
    return {op, sid, a, 8'h00, d};
  endfunction

  task automatic push(input logic [63:0] w);
    q[tail[5:0]] = w;
    tail = tail + 1;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && head != tail; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_rb();
    for (int i = 0; i < 30 && !rb_valid; i++) @(negedge clk);
  endtask

  // {sid, addr, data}
  localparam logic [51:0] TBL [6] = '{
    {4'd0, 16'h0001, 32'h1111_0001},
    {4'd1, 16'h0002, 32'h2222_0002},
    {4'd2, 16'h0003, 32'h3333_0003},
    {4'd3, 16'h000F, 32'hFFFF_000F},
    {4'd1, 16'h0004, 32'h2222_0004},
    {4'd2, 16'h000A, 32'h3333_000A}
  };

  int exp_cnt [NS];
  int base_cnt [NS];
  int exp_seq = 0;

  initial begin
    // R1: reset state with a malformed word (opcode 0) already waiting.
    @(negedge clk);
    push(mk(4'h0, 4'd0, 16'h0, 32'h0));
    repeat (3) @(negedge clk);
    chk("R1 fifo_ready in reset", fifo_ready, 0);
    chk("R1 flags in reset", {rb_valid, batch_done, err_flag, sub_wr_en, sub_rd_en}, 0);
    chk("R1 seq in reset", batch_seq, 0);
    rst = 0;
    @(negedge clk);
    chk("R7 bad opcode sets error", err_flag, 1);
    host_clr_err = 1; @(negedge clk); host_clr_err = 0;
    chk("R7 error cleared", err_flag, 0);
    chk("R8 no ready when empty", fifo_ready, 0);

    // R2/R4: table of write-then-read pairs.
    for (int s = 0; s < NS; s++) exp_cnt[s] = 0;
    for (int i = 0; i < 6; i++) begin
      push(mk(4'd1, TBL[i][51:48], TBL[i][47:32], TBL[i][31:0]));
      push(mk(4'd2, TBL[i][51:48], TBL[i][47:32], 32'h0));
      exp_cnt[TBL[i][49:48]]++;
      wait_rb();
      chk("R4 readback data", rb_data, TBL[i][31:0]);
      host_ack_rb = 1; @(negedge clk); host_ack_rb = 0;
      chk("R4 readback acked", rb_valid, 0);
    end
    drain();
    for (int s = 0; s < NS; s++) chk("R2 routed write count", wr_cnt[s], exp_cnt[s]);

    // R2: strobe timing and fields.
    push(mk(4'd1, 4'd3, 16'h0007, 32'h1234_5678));
    @(negedge clk);
    chk("R2 strobe lane", sub_wr_en, 4'b1000);
    chk("R2 addr field", sub_addr, 16'h0007);
    chk("R2 data field", sub_wdata, 32'h1234_5678);
    @(negedge clk);
    chk("R2 strobe one cycle", sub_wr_en, 0);
    drain();

    // R3: stall on not-ready target.
    sub_ready[2] = 1'b0;
    base_cnt[2] = wr_cnt[2];
    push(mk(4'd1, 4'd2, 16'h0009, 32'h0000_BEEF));
    repeat (5) @(negedge clk);
    chk("R3 no pop while not ready", fifo_ready, 0);
    chk("R3 no write while not ready", wr_cnt[2], base_cnt[2]);
    sub_ready[2] = 1'b1;
    #1;
    chk("R3 pop once ready", fifo_ready, 1);
    @(negedge clk);
    chk("R3 strobe after ready", sub_wr_en, 4'b0100);
    push(mk(4'd2, 4'd2, 16'h0009, 32'h0));
    wait_rb();
    chk("R3 stalled write applied", rb_data, 32'h0000_BEEF);
    host_ack_rb = 1; @(negedge clk); host_ack_rb = 0;
    drain();

    // R6: end-of-batch waits for pending writes.
    push(mk(4'd1, 4'd0, 16'h0002, 32'hA0A0_0002));
    push(mk(4'd1, 4'd1, 16'h0003, 32'hB1B1_0003));
    push(mk(4'd3, 4'd9, 16'h0, 32'h0));
    @(negedge clk);
    @(negedge clk);
    chk("R6 eob held behind write", fifo_ready, 0);
    chk("R6 not done early", batch_done, 0);
    @(negedge clk);
    chk("R6 eob pops when quiet", fifo_ready, 1);
    @(negedge clk);
    exp_seq++;
    chk("R6 done set", batch_done, 1);
    chk("R6 seq step", batch_seq, SW'(exp_seq));
    host_ack_done = 1; @(negedge clk); host_ack_done = 0;
    chk("R6 done cleared", batch_done, 0);

    // R5: capture coinciding with host acknowledge.
    push(mk(4'd2, 4'd0, 16'h0001, 32'h0));
    wait_rb();
    chk("R5 first read", rb_data, 32'h1111_0001);
    push(mk(4'd2, 4'd1, 16'h0002, 32'h0));
    @(negedge clk);
    @(negedge clk);
    host_ack_rb = 1;
    @(negedge clk);
    host_ack_rb = 0;
    chk("R5 valid kept on clash", rb_valid, 1);
    chk("R5 new data on clash", rb_data, 32'h2222_0002);
    host_ack_rb = 1; @(negedge clk); host_ack_rb = 0;
    chk("R4 cleared after ack", rb_valid, 0);

    // R7: bad identifier dropped while host clears the flag.
    for (int s = 0; s < NS; s++) base_cnt[s] = wr_cnt[s];
    push(mk(4'd1, 4'd9, 16'h0001, 32'hDEAD_DEAD));
    host_clr_err = 1;
    @(negedge clk);
    host_clr_err = 0;
    chk("R7 error wins over clear", err_flag, 1);
    push(mk(4'd5, 4'd0, 16'h0001, 32'hDEAD_0000));
    drain();
    for (int s = 0; s < NS; s++) chk("R7 dropped word wrote nothing", wr_cnt[s], base_cnt[s]);
    chk("R7 still sticky", err_flag, 1);
    host_clr_err = 1; @(negedge clk); host_clr_err = 0;
    chk("R7 cleared", err_flag, 0);
    chk("R8 idle ready low", fifo_ready, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule